// File: doc/BRIEF.md
# Per-Port Coherency Enable Controller

This block decides, for each upstream port of a coherent interconnect, whether that port may currently be sent snoop requests and distributed virtual memory (DVM) messages. Each port is governed by one of three sources. A coherency handshake interface controls the port when the port's bit is set in a management bitmap. A force-on mode lets the port follow its own upstream reset state. Otherwise software register writes control it. Every enable is masked by per-port capability inputs. These inputs are captured once, at the first transaction or register write after reset, and are ignored afterwards.

Whenever any effective enable changes, the block raises a change-pending status bit. It records how many transactions were outstanding at the moment of the change and keeps the bit set until that many completions have been seen. Transactions issued after the change cannot hold the bit set. Software can therefore tell when no transaction that might have observed the old enable value is still in flight.

Top module: `coh_enable_ctrl`

## Requirements
- R1: After reset, every snoop enable, every DVM enable and the change-pending bit are 0.
- R2: The capability inputs are captured on the first cycle after reset that has a transaction start or a software write. Later changes to the capability inputs have no effect on any enable.
- R3: A software enable for snoops or DVM on a port is ANDed with that port's captured capability bit. A disallowed enable shows as 0 on the enable output.
- R4: Bit i of the management bitmap makes port i managed by the handshake interface. A handshake message with join=1 enables snoop and DVM on that port, subject to R3 masking, and join=0 disables both. Software writes addressed to a managed port are ignored.
- R5: Handshake messages addressed to a port whose bitmap bit is clear are ignored.
- R6: In force-on mode, an unmanaged port's snoop enable equals (not in reset) AND its captured snoop capability, and likewise for DVM. The enable follows changes to the reset input.
- R7: Force-on mode has no effect on managed ports.
- R8: Leaving force-on mode restores each unmanaged port to its stored software setting.
- R9: When any effective enable changes, change-pending is set. It clears after as many completions as there were transactions outstanding, counting any started in that same cycle. Transactions started after the change are not counted.
- R10: An enable change made with no transaction outstanding leaves change-pending at 0.
- R11: Outputs are registered. An input applied before a clock edge is reflected on the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_snoop_i | input | NUM_PORTS | Per-port snoop capability (captured once) |
| cap_dvm_i | input | NUM_PORTS | Per-port DVM capability (captured once) |
| up_in_reset_i | input | NUM_PORTS | Per-port upstream reset state, 1 = in reset |
| hs_managed_i | input | NUM_PORTS | Bitmap of ports managed by the handshake interface |
| force_on_i | input | 1 | Force-on mode for unmanaged ports |
| txn_start_i | input | 1 | One transaction issued this cycle |
| txn_done_i | input | 1 | One transaction completed this cycle |
| sw_wr_i | input | 1 | Software write strobe |
| sw_port_i | input | PORT_W | Port addressed by the software write |
| sw_snoop_i | input | 1 | Requested snoop enable |
| sw_dvm_i | input | 1 | Requested DVM enable |
| hs_valid_i | input | 1 | Handshake message strobe |
| hs_port_i | input | PORT_W | Port that sent the handshake message |
| hs_join_i | input | 1 | 1 = enter coherency, 0 = leave |
| snoop_en_o | output | NUM_PORTS | Effective snoop enable per port |
| dvm_en_o | output | NUM_PORTS | Effective DVM enable per port |
| change_pending_o | output | 1 | An enable changed and older transactions are still in flight |

## Verification
The hardest situation to reach is a change-pending window that transactions issued after the change overlap. The change must see a known nonzero count of outstanding transactions, and new starts must arrive before the older completions. The stimulus first issues three transactions and then flips a software enable. It issues one more transaction and retires completions one at a time. The bit must drop on the third completion while one transaction is still outstanding. Lazy capture is reached by making the very first access a transaction start, then clearing the capability inputs before any enable is requested.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef struct packed {
    logic snp;
    logic dvm;
  } en_pair_t;
endpackage

// File: rtl/coh_cap_sampler.sv
module coh_cap_sampler #(
  parameter int NUM_PORTS = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 trig_i,
  input  logic [NUM_PORTS-1:0] cap_snp_i,
  input  logic [NUM_PORTS-1:0] cap_dvm_i,
  output logic [NUM_PORTS-1:0] cap_snp_d_o,
  output logic [NUM_PORTS-1:0] cap_dvm_d_o,
  output logic [NUM_PORTS-1:0] cap_snp_q_o,
  output logic [NUM_PORTS-1:0] cap_dvm_q_o
);
  logic taken_q;

  // Capture on the first access only; held afterwards.
  always_comb begin
    if (taken_q) begin
      cap_snp_d_o = cap_snp_q_o;
      cap_dvm_d_o = cap_dvm_q_o;
    end else if (trig_i) begin
      cap_snp_d_o = cap_snp_i;
      cap_dvm_d_o = cap_dvm_i;
    end else begin
      cap_snp_d_o = '0;
      cap_dvm_d_o = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      taken_q     <= 1'b0;
      cap_snp_q_o <= '0;
      cap_dvm_q_o <= '0;
    end else begin
      taken_q     <= taken_q | trig_i;
      cap_snp_q_o <= cap_snp_d_o;
      cap_dvm_q_o <= cap_dvm_d_o;
    end
  end

  // R2: once captured, the capability bits never move
  p_caps_hold_r2: assert property (@(posedge clk) disable iff (rst)
    taken_q |=> ($stable(cap_snp_q_o) && $stable(cap_dvm_q_o)));
endmodule

// File: rtl/coh_port_slice.sv
module coh_port_slice
  import coh_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     managed_i,
  input  logic     force_i,
  input  logic     in_reset_i,
  input  en_pair_t cap_i,
  input  logic     sw_we_i,
  input  en_pair_t sw_i,
  input  logic     hs_we_i,
  input  logic     hs_join_i,
  output en_pair_t eff_o,
  output logic     chg_o
);
  en_pair_t sw_req_q, sw_req_d;
  logic     hs_req_q, hs_req_d;
  en_pair_t eff_d;

  always_comb begin
    sw_req_d = (sw_we_i && !managed_i) ? sw_i : sw_req_q;
    hs_req_d = (hs_we_i && managed_i) ? hs_join_i : hs_req_q;
    if (managed_i) begin
      eff_d.snp = hs_req_d & cap_i.snp;
      eff_d.dvm = hs_req_d & cap_i.dvm;
    end else if (force_i) begin
      eff_d.snp = !in_reset_i & cap_i.snp;
      eff_d.dvm = !in_reset_i & cap_i.dvm;
    end else begin
      eff_d.snp = sw_req_d.snp & cap_i.snp;
      eff_d.dvm = sw_req_d.dvm & cap_i.dvm;
    end
    chg_o = (eff_d != eff_o);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_req_q <= '0;
      hs_req_q <= 1'b0;
      eff_o    <= '0;
    end else begin
      sw_req_q <= sw_req_d;
      hs_req_q <= hs_req_d;
      eff_o    <= eff_d;
    end
  end

  // R1: first cycle out of reset shows nothing enabled
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (eff_o == '0));
  // R6: a forced port whose upstream is in reset is never enabled next cycle
  p_force_reset_r6: assert property (@(posedge clk) disable iff (rst)
    (force_i && !managed_i && in_reset_i) |=> (eff_o == '0));
endmodule

// File: rtl/coh_drain_tracker.sv
module coh_drain_tracker #(
  parameter int CNT_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic done_i,
  input  logic chg_i,
  output logic pending_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] outst_q, outst_d;
  logic [CNT_W-1:0] drain_q, drain_d;

  always_comb begin
    outst_d = outst_q;
    if (start_i && !done_i && outst_q != CNT_MAX)
      outst_d = outst_q + 1'b1;
    else if (done_i && !start_i && outst_q != '0)
      outst_d = outst_q - 1'b1;

    if (chg_i)
      drain_d = outst_d;
    else if (done_i && drain_q != '0)
      drain_d = drain_q - 1'b1;
    else
      drain_d = drain_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outst_q <= '0;
      drain_q <= '0;
    end else begin
      outst_q <= outst_d;
      drain_q <= drain_d;
    end
  end

  assign pending_o = (drain_q != '0);

  // R9: outstanding counter never wraps
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    (outst_q == CNT_MAX) |-> !(start_i && !done_i));
  // R9: each completion without a new change retires one drain entry
  p_drain_step_r9: assert property (@(posedge clk) disable iff (rst)
    (drain_q != '0 && done_i && !chg_i) |=> (drain_q == $past(drain_q) - 1'b1));
  // R10: change with nothing in flight leaves status clear
  p_idle_change_r10: assert property (@(posedge clk) disable iff (rst)
    (chg_i && outst_q == '0 && !start_i) |=> !pending_o);
endmodule

// File: rtl/coh_enable_ctrl.sv
module coh_enable_ctrl
  import coh_pkg::*;
#(
  parameter int NUM_PORTS = 7,
  parameter int CNT_W     = 8,
  parameter int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PORTS-1:0] cap_snoop_i,
  input  logic [NUM_PORTS-1:0] cap_dvm_i,
  input  logic [NUM_PORTS-1:0] up_in_reset_i,
  input  logic [NUM_PORTS-1:0] hs_managed_i,
  input  logic                 force_on_i,
  input  logic                 txn_start_i,
  input  logic                 txn_done_i,
  input  logic                 sw_wr_i,
  input  logic [PORT_W-1:0]    sw_port_i,
  input  logic                 sw_snoop_i,
  input  logic                 sw_dvm_i,
  input  logic                 hs_valid_i,
  input  logic [PORT_W-1:0]    hs_port_i,
  input  logic                 hs_join_i,
  output logic [NUM_PORTS-1:0] snoop_en_o,
  output logic [NUM_PORTS-1:0] dvm_en_o,
  output logic                 change_pending_o
);
  logic [NUM_PORTS-1:0] cap_snp_d, cap_dvm_d, cap_snp_q, cap_dvm_q;
  logic [NUM_PORTS-1:0] chg_vec;

  coh_cap_sampler #(.NUM_PORTS(NUM_PORTS)) u_caps (
    .clk        (clk),
    .rst        (rst),
    .trig_i     (txn_start_i | sw_wr_i),
    .cap_snp_i  (cap_snoop_i),
    .cap_dvm_i  (cap_dvm_i),
    .cap_snp_d_o(cap_snp_d),
    .cap_dvm_d_o(cap_dvm_d),
    .cap_snp_q_o(cap_snp_q),
    .cap_dvm_q_o(cap_dvm_q)
  );

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    en_pair_t cap_w, sw_w, eff_w;
    assign cap_w.snp = cap_snp_d[i];
    assign cap_w.dvm = cap_dvm_d[i];
    assign sw_w.snp  = sw_snoop_i;
    assign sw_w.dvm  = sw_dvm_i;

    coh_port_slice u_slice (
      .clk       (clk),
      .rst       (rst),
      .managed_i (hs_managed_i[i]),
      .force_i   (force_on_i),
      .in_reset_i(up_in_reset_i[i]),
      .cap_i     (cap_w),
      .sw_we_i   (sw_wr_i && (sw_port_i == PORT_W'(i))),
      .sw_i      (sw_w),
      .hs_we_i   (hs_valid_i && (hs_port_i == PORT_W'(i))),
      .hs_join_i (hs_join_i),
      .eff_o     (eff_w),
      .chg_o     (chg_vec[i])
    );

    assign snoop_en_o[i] = eff_w.snp;
    assign dvm_en_o[i]   = eff_w.dvm;
  end

  coh_drain_tracker #(.CNT_W(CNT_W)) u_drain (
    .clk      (clk),
    .rst      (rst),
    .start_i  (txn_start_i),
    .done_i   (txn_done_i),
    .chg_i    (|chg_vec),
    .pending_o(change_pending_o)
  );

  // R3: no enable is ever on without its captured capability
  p_cap_mask_r3: assert property (@(posedge clk) disable iff (rst)
    ((snoop_en_o & ~cap_snp_q) == '0) && ((dvm_en_o & ~cap_dvm_q) == '0));
endmodule

// File: tb/coh_enable_ctrl_tb.sv
module coh_enable_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 7;
  localparam int PW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] cap_snoop, cap_dvm, in_rst, managed;
  logic force_on, t_start, t_done, sw_wr, sw_snp, sw_dvm, hs_v, hs_join;
  logic [PW-1:0] sw_port, hs_port;
  logic [N-1:0] snp_en, dvm_en;
  logic pending;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  coh_enable_ctrl #(.NUM_PORTS(N), .CNT_W(8)) dut_i (
    .clk(clk), .rst(rst),
    .cap_snoop_i(cap_snoop), .cap_dvm_i(cap_dvm),
    .up_in_reset_i(in_rst), .hs_managed_i(managed),
    .force_on_i(force_on), .txn_start_i(t_start), .txn_done_i(t_done),
    .sw_wr_i(sw_wr), .sw_port_i(sw_port), .sw_snoop_i(sw_snp), .sw_dvm_i(sw_dvm),
    .hs_valid_i(hs_v), .hs_port_i(hs_port), .hs_join_i(hs_join),
    .snoop_en_o(snp_en), .dvm_en_o(dvm_en), .change_pending_o(pending)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic start_txn();
    t_start = 1'b1; tick(); t_start = 1'b0;
  endtask

  task automatic done_txn();
    t_done = 1'b1; tick(); t_done = 1'b0;
  endtask

  task automatic sw_write(input int p, input logic s, input logic d);
    sw_wr = 1'b1; sw_port = PW'(p); sw_snp = s; sw_dvm = d;
    tick();
    sw_wr = 1'b0;
  endtask

  task automatic hs_msg(input int p, input logic j);
    hs_v = 1'b1; hs_port = PW'(p); hs_join = j;
    tick();
    hs_v = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 snoop", 32'(snp_en), 32'h0);
    check("R1 dvm", 32'(dvm_en), 32'h0);
    check("R1 pending", 32'(pending), 32'h0);
  endtask

  task automatic t_lazy_sample();
    start_txn();                     // first access: captures caps
    cap_snoop = '0; cap_dvm = '0;    // later changes must not matter
    sw_write(2, 1'b1, 1'b1);
    check("R2 snoop p2 after cap drop", 32'(snp_en), 32'b0000100);
    check("R11 dvm p2 visible after one edge", 32'(dvm_en), 32'b0000100);
    check("R9 pending with one in flight", 32'(pending), 32'h1);
    sw_write(1, 1'b1, 1'b1);
    check("R3 snoop p1", 32'(snp_en), 32'b0000110);
    check("R3 dvm p1 masked", 32'(dvm_en), 32'b0000100);
    done_txn();
    check("R9 pending cleared", 32'(pending), 32'h0);
  endtask

  task automatic t_handshake();
    sw_write(0, 1'b1, 1'b1);
    check("R4 sw write to managed ignored", 32'(snp_en), 32'b0000110);
    hs_msg(3, 1'b1);
    check("R5 hs to unmanaged ignored snoop", 32'(snp_en), 32'b0000110);
    check("R5 hs to unmanaged ignored dvm", 32'(dvm_en), 32'b0000100);
    hs_msg(6, 1'b1);
    check("R4 hs join p6 snoop", 32'(snp_en), 32'b1000110);
    check("R4 hs join p6 dvm masked", 32'(dvm_en), 32'b0000100);
    check("R10 idle change", 32'(pending), 32'h0);
  endtask

  task automatic t_force();
    in_rst = 7'b0010000;
    force_on = 1'b1;
    tick();
    check("R6 force snoop", 32'(snp_en), 32'b1101110);
    check("R6 force dvm", 32'(dvm_en), 32'b0101100);
    check("R7 managed p0 unaffected", 32'(snp_en[0]), 32'h0);
    in_rst = '0;
    tick();
    check("R6 follows reset release snoop", 32'(snp_en), 32'b1111110);
    check("R6 follows reset release dvm", 32'(dvm_en), 32'b0111100);
    force_on = 1'b0;
    tick();
    check("R8 restore snoop", 32'(snp_en), 32'b1000110);
    check("R8 restore dvm", 32'(dvm_en), 32'b0000100);
  endtask

  task automatic t_drain();
    start_txn(); start_txn(); start_txn();
    sw_write(3, 1'b1, 1'b0);
    check("R9 snoop p3 on", 32'(snp_en), 32'b1001110);
    check("R9 pending set", 32'(pending), 32'h1);
    start_txn();                     // issued after change: not counted
    done_txn(); done_txn();
    check("R9 pending after two of three", 32'(pending), 32'h1);
    done_txn();
    check("R9 pending clear with newer txn left", 32'(pending), 32'h0);
    done_txn();
    sw_write(3, 1'b0, 1'b0);
    check("R10 no outstanding no pending", 32'(pending), 32'h0);
    check("R10 snoop p3 off", 32'(snp_en), 32'b1000110);
  endtask

  task automatic t_leave();
    hs_msg(6, 1'b0);
    check("R4 hs leave p6", 32'(snp_en), 32'b0000110);
  endtask

  initial begin
    cap_snoop = 7'h7F; cap_dvm = 7'b0111101;
    in_rst = '0; managed = 7'b1000001; force_on = 1'b0;
    t_start = 0; t_done = 0; sw_wr = 0; sw_snp = 0; sw_dvm = 0;
    hs_v = 0; hs_join = 0; sw_port = '0; hs_port = '0;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_lazy_sample();
    t_handshake();
    t_force();
    t_drain();
    t_leave();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule